// File: doc/BRIEF.md
# Serial Shift Register Unit

This block moves one byte at a time over a two-wire serial link: a data line and a clock line. A 3-bit mode input picks the direction and the source of the bit clock. The source is a programmable rate derived from an 8-bit reload value, the system clock, or a clock arriving on an input pin. The data byte sits in one register. The processor writes it, and reads it back through a parallel port.

A transfer starts when the processor touches the register in the direction that matches the mode: a read in a receive mode, or a write in a send mode. Eight bit moves later the unit stops and raises an interrupt request. One send mode runs without end and recirculates the byte, so the line carries the same pattern over and over. When the unit makes the bit clock itself, it drives that clock on an output pin. The pin rests high between transfers.

Top module: `serial_shifter`

## Requirements
- R1: Mode encoding on `mode`: 0 off, 1 receive at timer rate, 2 receive at system rate, 3 receive on external clock, 4 endless send at timer rate, 5 send at timer rate, 6 send at system rate, 7 send on external clock. In mode 0 no bit ever moves, and `sclk_out` stays 1. Accesses in mode 0 start nothing.
- R2: On each bit move in a send mode, the old bit 7 of the register appears on `sdata_out` and the register rotates left, so bit 7 comes back in at bit 0.
- R3: On each bit move in a receive mode, the register shifts left and `sdata_in`, sampled at that clock edge, enters at bit 0.
- R4: A 3-bit counter counts the bit moves modulo 8. When it wraps, the transfer stops and `irq` goes to 1 in the same cycle as the eighth move.
- R5: Mode 4 never stops and never raises `irq`. After 8k moves the register again holds the byte that was written.
- R6: In modes 2 and 6, the n-th bit moves on the 2n-th rising clock edge after the starting access edge.
- R7: In modes 1, 4 and 5, one bit moves every (reload+2)×2 clock cycles, where reload is `rate_reload`.
- R8: In the internally clocked modes, `sclk_out` falls after the first half bit period and rises on each bit move, so it toggles every half period. It is 1 whenever no transfer is running.
- R9: A read (`cpu_rd`) in modes 1–3, or a write (`cpu_wr`) in modes 4–7, restarts the bit counter and clears `irq`. A read in a send mode starts nothing and changes nothing. A write in a receive mode only loads the register.
- R10: In modes 3 and 7, each low-to-high change of `sclk_in` moves one bit while a transfer is running, and `sclk_out` stays 1.
- R11: Any change of `mode` stops a running transfer and clears the bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Clock source and direction select |
| rate_reload | input | 8 | Reload value that sets the timer-derived bit rate |
| cpu_wr | input | 1 | Processor write strobe for the data register |
| cpu_rd | input | 1 | Processor read strobe for the data register |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Current contents of the data register |
| sclk_in | input | 1 | External bit clock |
| sdata_in | input | 1 | Serial data input |
| sclk_out | output | 1 | Bit clock driven in the internally clocked modes |
| sdata_out | output | 1 | Serial data output |
| irq | output | 1 | Transfer-complete interrupt request |

## Verification
Three kinds of internal fault show up in different places. A wrong half-period count or phase shows first on `sclk_out`, within one half period of the starting access, and it also moves the cycle in which `irq` rises. A wrong bit counter shows only when the transfer ends, as `irq` arriving early, late or never. It is therefore checked by the exact cycle of the `irq` rise against 16 half periods. A fault in the shift path shows on `sdata_out` at the next bit move, or in `cpu_rdata` after the eighth move. A run flag that fails to drop after a mode change shows as register contents that keep moving.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [2:0] {
    SM_OFF      = 3'd0,
    SM_IN_TMR   = 3'd1,
    SM_IN_SYS   = 3'd2,
    SM_IN_EXT   = 3'd3,
    SM_OUT_FREE = 3'd4,
    SM_OUT_TMR  = 3'd5,
    SM_OUT_SYS  = 3'd6,
    SM_OUT_EXT  = 3'd7
  } ssr_mode_e;

  function automatic logic mode_is_out(input logic [2:0] m);
    return m[2];
  endfunction

  function automatic logic mode_is_ext(input logic [2:0] m);
    return m[1:0] == 2'b11;
  endfunction

  function automatic logic mode_is_timer(input logic [2:0] m);
    return (m == SM_IN_TMR) || (m == SM_OUT_FREE) || (m == SM_OUT_TMR);
  endfunction

  function automatic logic mode_is_internal(input logic [2:0] m);
    return (m != SM_OFF) && !mode_is_ext(m);
  endfunction

endpackage

// File: rtl/ssr_edge_det.sv
module ssr_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sclk_in;
  end

  assign rise = sclk_in && !prev_q;
endmodule

// File: rtl/ssr_rate_gen.sv
module ssr_rate_gen #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              enable,
  input  logic              use_timer,
  input  logic [RATE_W-1:0] reload,
  output logic              sclk_o,
  output logic              tick
);
  localparam int HALF_W = RATE_W + 1;

  // Half bit period in clocks: reload+2 for timer rate, 1 for system rate.
  function automatic logic [HALF_W-1:0] half_len(input logic tmr,
                                                 input logic [RATE_W-1:0] r);
    return tmr ? (HALF_W'(r) + HALF_W'(2)) : HALF_W'(1);
  endfunction

  logic [HALF_W-1:0] phase_q;
  logic [HALF_W-1:0] half;
  logic              at_end;
  logic              sclk_q;

  assign half   = half_len(use_timer, reload);
  assign at_end = (phase_q == half - HALF_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sclk_q  <= 1'b1;
    end else if (restart) begin
      phase_q <= '0;
      sclk_q  <= 1'b1;
    end else if (enable) begin
      if (at_end) begin
        phase_q <= '0;
        sclk_q  <= ~sclk_q;
      end else begin
        phase_q <= phase_q + HALF_W'(1);
      end
    end
  end

  assign sclk_o = sclk_q;
  // A bit moves on the rising half of the generated clock.
  assign tick   = enable && !restart && at_end && !sclk_q;
endmodule

// File: rtl/ssr_datapath.sv
module ssr_datapath #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_out,
  input  logic              free_run,
  input  logic              mode_chg,
  input  logic              start,
  input  logic              shift_ev,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              sdata_in,
  output logic              running,
  output logic [DATA_W-1:0] sr_q,
  output logic              sdata_o,
  output logic              irq_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] rotl(input logic [DATA_W-1:0] v);
    return {v[DATA_W-2:0], v[DATA_W-1]};
  endfunction

  function automatic logic [DATA_W-1:0] shl_in(input logic [DATA_W-1:0] v,
                                               input logic b);
    return {v[DATA_W-2:0], b};
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      sdata_o <= 1'b0;
      cnt_q   <= '0;
      running <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (load)          sr_q <= load_data;
      else if (shift_ev) sr_q <= dir_out ? rotl(sr_q) : shl_in(sr_q, sdata_in);

      if (shift_ev && dir_out) sdata_o <= sr_q[DATA_W-1];

      if (mode_chg) begin
        running <= 1'b0;
        cnt_q   <= '0;
      end else if (start) begin
        running <= 1'b1;
        cnt_q   <= '0;
        irq_o   <= 1'b0;
      end else if (shift_ev) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          if (!free_run) begin
            running <= 1'b0;
            irq_o   <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter
  import ssr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [RATE_W-1:0] rate_reload,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              sclk_in,
  input  logic              sdata_in,
  output logic              sclk_out,
  output logic              sdata_out,
  output logic              irq
);
  logic [2:0] mode_q;
  logic       mode_chg;
  logic       start;
  logic       tick;
  logic       ext_rise;
  logic       shift_ev;
  logic       running;
  logic       rate_restart;
  logic       rate_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= SM_OFF;
    else        mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
  assign start    = !mode_chg &&
                    ((cpu_rd && mode != SM_OFF && !mode_is_out(mode)) ||
                     (cpu_wr && mode_is_out(mode)));

  ssr_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .rise    (ext_rise)
  );

  assign rate_restart = start || mode_chg || !running;
  assign rate_en      = running && mode_is_internal(mode);

  ssr_rate_gen #(.RATE_W(RATE_W)) u_rate (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (rate_restart),
    .enable    (rate_en),
    .use_timer (mode_is_timer(mode)),
    .reload    (rate_reload),
    .sclk_o    (sclk_out),
    .tick      (tick)
  );

  assign shift_ev = running && !start && !mode_chg &&
                    (mode_is_ext(mode) ? ext_rise : tick);

  ssr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_out   (mode_is_out(mode)),
    .free_run  (mode == SM_OUT_FREE),
    .mode_chg  (mode_chg),
    .start     (start),
    .shift_ev  (shift_ev),
    .load      (cpu_wr),
    .load_data (cpu_wdata),
    .sdata_in  (sdata_in),
    .running   (running),
    .sr_q      (cpu_rdata),
    .sdata_o   (sdata_out),
    .irq_o     (irq)
  );
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode,
  input logic              cpu_wr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              sdata_in,
  input logic              sdata_out,
  input logic              sclk_out,
  input logic              irq,
  input logic              start,
  input logic              shift_ev,
  input logic              running,
  input logic              mode_chg
);
  // R1: mode 0 holds the register unless written
  a_r1_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !cpu_wr) |=> $stable(cpu_rdata));

  // R2: send move rotates and puts old MSB on the line
  a_r2_out_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && mode[2]) |=>
      (sdata_out == $past(cpu_rdata[DATA_W-1]) &&
       cpu_rdata == {$past(cpu_rdata[DATA_W-2:0]), $past(cpu_rdata[DATA_W-1])}));

  // R3: receive move enters serial bit at LSB
  a_r3_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_ev && !mode[2] && !cpu_wr) |=>
      cpu_rdata == {$past(cpu_rdata[DATA_W-2:0]), $past(sdata_in)});

  // R4: irq only rises on a bit move
  a_r4_irq_on_move: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(shift_ev));

  // R5: endless mode keeps running
  a_r5_free_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !mode_chg && running) |=> running);

  // R8: clock rests high when idle
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> sclk_out);

  // R9: a starting access clears irq
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !irq);

  // R10: external modes never drive the clock low
  a_r10_ext_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1:0] == 2'b11) |=> sclk_out);

  // R11: a mode change stops the transfer
  a_r11_mode_stop: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !running);
endmodule

bind serial_shifter ssr_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .cpu_wr    (cpu_wr),
  .cpu_rdata (cpu_rdata),
  .sdata_in  (sdata_in),
  .sdata_out (sdata_out),
  .sclk_out  (sclk_out),
  .irq       (irq),
  .start     (start),
  .shift_ev  (shift_ev),
  .running   (running),
  .mode_chg  (mode_chg)
);

// File: tb/serial_shifter_tb.sv
module serial_shifter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [7:0] rate_reload = 8'd0;
  logic       cpu_wr = 1'b0;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = 8'd0;
  logic [7:0] cpu_rdata;
  logic       sclk_in = 1'b0;
  logic       sdata_in = 1'b0;
  logic       sclk_out;
  logic       sdata_out;
  logic       irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rate_reload(rate_reload),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_out(sclk_out), .sdata_out(sdata_out), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = wr; cpu_rd = !wr; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic set_mode(input logic [2:0] m, input logic [7:0] r);
    @(negedge clk);
    mode = m; rate_reload = r;
    @(negedge clk);
  endtask

  // One full internally clocked transfer, checked cycle by cycle.
  task automatic run_internal(input logic [2:0] m, input logic [7:0] r, input logic [7:0] d);
    int h;
    int irq_at;
    bit clk_ok;
    bit dat_ok;
    h = (m == 3'd1 || m == 3'd4 || m == 3'd5) ? int'(r) + 2 : 1;
    irq_at = -1; clk_ok = 1'b1; dat_ok = 1'b1;
    set_mode(m, r);
    access(m[2], d);
    for (int c = 1; c <= 16 * h; c++) begin
      if (!m[2] && (c % (2 * h)) == 0) sdata_in = d[8 - c / (2 * h)];
      @(negedge clk);
      if (sclk_out !== (((c / h) % 2 == 0) ? 1'b1 : 1'b0)) clk_ok = 1'b0;
      if (m[2] && (c % (2 * h)) == 0 && sdata_out !== d[8 - c / (2 * h)]) dat_ok = 1'b0;
      if (irq && irq_at < 0) irq_at = c;
    end
    chk(clk_ok, "R8 sclk_out half-period waveform", sclk_out, 1);
    if (m[2]) chk(dat_ok, "R2 sdata_out MSB-first bits", dat_ok, 1);
    chk(irq_at == 16 * h, (h == 1) ? "R6/R4 irq cycle at system rate" : "R7/R4 irq cycle at timer rate",
        irq_at, 16 * h);
    chk(cpu_rdata == d, m[2] ? "R2 register after 8 rotations" : "R3 received byte",
        cpu_rdata, d);
  endtask

  task automatic ext_pulse(input logic b);
    @(negedge clk);
    sdata_in = b; sclk_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sclk_in = 1'b0;
    @(negedge clk);
  endtask

  // {mode, reload, data}
  localparam logic [18:0] VEC [6] = '{
    {3'd6, 8'd0, 8'hA5},
    {3'd5, 8'd1, 8'h3C},
    {3'd2, 8'd0, 8'hC9},
    {3'd1, 8'd0, 8'h5E},
    {3'd5, 8'd0, 8'h81},
    {3'd1, 8'd3, 8'h96}
  };

  initial begin
    #(10 * 50000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit ok;
    int irq_at;
    logic irq_keep;
    repeat (3) @(negedge clk);
    // reset state
    chk(irq == 1'b0, "R4 irq after reset", irq, 0);
    chk(sclk_out == 1'b1, "R8 sclk_out after reset", sclk_out, 1);
    chk(cpu_rdata == 8'h00, "R1 register after reset", cpu_rdata, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++)
      run_internal(VEC[i][18:16], VEC[i][15:8], VEC[i][7:0]);

    // R5: endless send, 24 bits at h=2
    set_mode(3'd4, 8'd0);
    d = 8'h93;
    access(1'b1, d);
    ok = 1'b1;
    for (int c = 1; c <= 96; c++) begin
      @(negedge clk);
      if ((c % 4) == 0 && sdata_out !== d[7 - ((c / 4 - 1) % 8)]) ok = 1'b0;
      if (irq) ok = 1'b0;
    end
    chk(ok, "R5 endless send bits and no irq", ok, 1);
    chk(cpu_rdata == d, "R5 register after 24 moves", cpu_rdata, d);

    // R10: external send
    set_mode(3'd7, 8'd0);
    d = 8'hB2;
    access(1'b1, d);
    ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ext_pulse(1'b0);
      if (sdata_out !== d[7 - k] || sclk_out !== 1'b1) ok = 1'b0;
      if (k == 6) chk(irq == 1'b0, "R10 no irq after 7 ext edges", irq, 0);
    end
    chk(ok, "R10 ext send bits, sclk_out high", ok, 1);
    chk(irq == 1'b1, "R10 irq after 8 ext edges", irq, 1);

    // R10: external receive
    set_mode(3'd3, 8'd0);
    d = 8'h6D;
    access(1'b0, 8'h00);
    for (int k = 0; k < 8; k++) ext_pulse(d[7 - k]);
    chk(cpu_rdata == d, "R10 ext receive byte", cpu_rdata, d);

    // R11: mode change mid-transfer
    set_mode(3'd6, 8'd0);
    access(1'b1, 8'hF0);
    repeat (6) @(negedge clk);
    mode = 3'd2;
    repeat (20) @(negedge clk);
    chk(cpu_rdata == 8'h87, "R11 register frozen after mode change", cpu_rdata, 8'h87);
    chk(irq == 1'b0, "R11 no irq after aborted transfer", irq, 0);
    set_mode(3'd6, 8'd0);
    access(1'b1, 8'h0F);
    irq_at = -1;
    for (int c = 1; c <= 20; c++) begin
      @(negedge clk);
      if (irq && irq_at < 0) irq_at = c;
    end
    chk(irq_at == 16, "R11 fresh 8-bit count after restart", irq_at, 16);

    // R9: non-starting accesses
    access(1'b0, 8'h00);
    repeat (10) @(negedge clk);
    chk(irq == 1'b1 && cpu_rdata == 8'h0F, "R9 read in send mode no effect", {irq, cpu_rdata}, 9'h10F);
    set_mode(3'd2, 8'd0);
    access(1'b1, 8'h44);
    repeat (10) @(negedge clk);
    chk(irq == 1'b1 && cpu_rdata == 8'h44, "R9 write in receive mode loads only", {irq, cpu_rdata}, 9'h144);
    access(1'b0, 8'h00);
    chk(irq == 1'b0, "R9 read in receive mode clears irq", irq, 0);

    // R1: mode 0
    set_mode(3'd0, 8'd0);
    irq_keep = irq;
    access(1'b1, 8'h5A);
    access(1'b0, 8'h00);
    ext_pulse(1'b1);
    ok = 1'b1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (sclk_out !== 1'b1) ok = 1'b0;
    end
    chk(ok && cpu_rdata == 8'h5A && irq == irq_keep, "R1 mode 0 idle", cpu_rdata, 8'h5A);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule